// File: doc/BRIEF.md
# NOR Flash Program and Erase Engine

This block holds a small on-chip byte array that stands in for a NOR flash memory and applies flash rules to it. A command front end, which has already gathered the opcode, address and data, hands it one request at a time. It also supplies the state of the write-enable latch and two capability bits that say which small erase sizes the emulated device supports. A program request changes one byte in a single clock. An erase request fills an aligned region with 0xFF, one byte per clock, and holds `busy` high until the region is finished.

The engine signals results with one-cycle pulses. `done` marks a completed operation. `err` marks a request that was refused. `zero_to_one` marks a program that tried to raise a cleared bit. A separate read port with one cycle of latency lets the front end, or a bench, look at any byte. After reset the engine fills the whole array with 0xFF in the same way, so no memory reset is needed.

The region sizes are parameters given as powers of two. A real part would use 12 (4 KiB), 15 (32 KiB) and 16 (sector). The defaults are 4, 7 and 8 over a 1 KiB array so that the array stays small. Each region must be no larger than the array.

Top module: `nor_prog_erase_engine`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `err`, `done` and `zero_to_one` are 0. After reset is released, `busy` stays high for exactly 2^ADDR_W cycles while every byte is set to 0xFF. In the cycle after `busy` falls, `done` pulses.
- R2: With EEPROM_MODE=0, an accepted program (`req_op`=0) stores the old byte ANDed with `req_data`, so no stored bit can go from 0 to 1. The new value is readable from the next cycle.
- R3: With EEPROM_MODE=1, an accepted program stores `req_data` unchanged, so bits may return to 1.
- R4: With EEPROM_MODE=0, `zero_to_one` pulses for one cycle, in the cycle after an accepted program, when `req_data` has a 1 where the stored byte has a 0. The byte still takes the AND value.
- R5: An accepted erase first aligns `req_addr` down to the region size. It then writes 0xFF to every byte of that region and leaves all bytes outside it unchanged.
- R6: Erase op codes and their sizes are:
  - 1: 2^SUB_LOG2 bytes
  - 2: 2^MID_LOG2 bytes
  - 3: 2^SECTOR_LOG2 bytes
  - 4: the whole array
- R7: An op-1 erase while `cap_sub` is 0, or an op-2 erase while `cap_mid` is 0, is refused. The refusal raises `err` for one cycle in the next cycle and leaves the array unchanged. Op 3 and op 4 need no capability bit.
- R8: Any request made while `wel` is 0 is refused with an `err` pulse and changes no byte.
- R9: After an accepted erase of N bytes, `busy` is high for exactly the N cycles that follow the accepting edge. `done` pulses in the cycle after that. After an accepted program, `done` pulses in the next cycle and `busy` stays low.
- R10: A request that arrives while `busy` is high is refused with an `err` pulse and has no effect on the array.
- R11: `rd_data` shows the byte at `rd_addr` one clock after the address is presented.
- R12: A request with an op code of 5, 6 or 7 is refused with an `err` pulse and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the power-up fill |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | 0 program, 1 small erase, 2 mid erase, 3 sector erase, 4 whole-array erase |
| req_addr | input | ADDR_W | Byte address; for an erase, any address inside the region |
| req_data | input | 8 | Program data |
| wel | input | 1 | Current write-enable latch |
| cap_sub | input | 1 | Device supports the small erase size |
| cap_mid | input | 1 | Device supports the mid erase size |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | 8 | Byte at rd_addr, one cycle later |
| busy | output | 1 | Fill in progress; new requests are refused |
| done | output | 1 | One-cycle pulse when an operation completes |
| err | output | 1 | One-cycle pulse when a request is refused |
| zero_to_one | output | 1 | One-cycle diagnostic pulse for an attempt to raise a cleared bit |

## Verification
The hardest case to reach is a request that arrives while an erase is part-way through. At that point the array holds a mix of cleared and old bytes, and a refused program must leave no mark anywhere. The stimulus starts a sector erase, issues a program to a byte outside that sector on the very next cycle, and then waits for the fill to finish. It then reads back the erased sector, the neighbour just below it, and the byte the refused program aimed at. Alignment is exercised by erasing with addresses in the middle or at the top of a region, with marker bytes programmed just outside its bounds beforehand.

// File: rtl/nor_eng_pkg.sv
// Shared definitions for the NOR program/erase engine.
// Assumes the request op field is three bits wide.
package nor_eng_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PROGRAM      = 3'd0,
        OP_ERASE_SUB    = 3'd1,
        OP_ERASE_MID    = 3'd2,
        OP_ERASE_SECTOR = 3'd3,
        OP_ERASE_CHIP   = 3'd4
    } nor_op_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nor_req_screen.sv
// Request screen: decides whether a request is accepted as a program,
// accepted as an erase, or refused. It also gives the region mask for an erase.
// Assumes every region size is a power of two no larger than the array.
module nor_req_screen
    import nor_eng_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned SUB_LOG2    = 4,
    parameter int unsigned MID_LOG2    = 7,
    parameter int unsigned SECTOR_LOG2 = 8
) (
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic              wel,
    input  logic              cap_sub,
    input  logic              cap_mid,
    input  logic              busy,
    output logic              prog_go,
    output logic              erase_go,
    output logic              reject,
    output logic [ADDR_W-1:0] erase_mask
);

    localparam logic [ADDR_W-1:0] SUB_MASK    = ADDR_W'((64'd1 << SUB_LOG2) - 64'd1);
    localparam logic [ADDR_W-1:0] MID_MASK    = ADDR_W'((64'd1 << MID_LOG2) - 64'd1);
    localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'((64'd1 << SECTOR_LOG2) - 64'd1);

    logic known_op;
    logic size_ok;
    logic is_prog;
    logic permit;

    // Decode the op: is it legal, is the size supported, and which mask applies.
    always_comb begin
        known_op   = 1'b1;
        size_ok    = 1'b1;
        is_prog    = 1'b0;
        erase_mask = '1;
        case (req_op)
            OP_PROGRAM: begin
                is_prog    = 1'b1;
                erase_mask = '0;
            end
            OP_ERASE_SUB: begin
                erase_mask = SUB_MASK;
                size_ok    = cap_sub;
            end
            OP_ERASE_MID: begin
                erase_mask = MID_MASK;
                size_ok    = cap_mid;
            end
            OP_ERASE_SECTOR: erase_mask = SECTOR_MASK;
            OP_ERASE_CHIP:   erase_mask = '1;
            default:         known_op   = 1'b0;
        endcase
    end

    // Combine the decode with the latch and busy state to form the verdict.
    always_comb begin
        permit   = known_op && size_ok && wel && !busy;
        prog_go  = req_valid && permit && is_prog;
        erase_go = req_valid && permit && !is_prog;
        reject   = req_valid && !permit;
    end

endmodule

// File: rtl/nor_fill_seq.sv
// Fill sequencer: walks an aligned region one byte per clock and asks the
// store to write 0xFF to each address. Reset loads a whole-array walk, so the
// array is cleared at power-up. Assumes start only arrives while idle.
module nor_fill_seq #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] start_mask,
    output logic              busy,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fin
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] idx_q;

    // Hold the region, step the offset, and flag the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b1;
            base_q <= '0;
            mask_q <= '1;
            idx_q  <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (busy) begin
                if (idx_q == mask_q) begin
                    busy  <= 1'b0;
                    fin   <= 1'b1;
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (start) begin
                busy   <= 1'b1;
                base_q <= start_addr & ~start_mask;
                mask_q <= start_mask;
                idx_q  <= '0;
            end
        end
    end

    // Form the current write address from the aligned base and the offset.
    always_comb begin
        fill_we   = busy;
        fill_addr = base_q | idx_q;
    end

    AST_FELL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> fin);  // R9
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);  // R10

endmodule

// File: rtl/nor_byte_store.sv
// Byte store: the emulated flash array. It has one write port shared by the
// fill path and the program path, and one registered read port.
// Assumes the fill and program writes never coincide.
module nor_byte_store
    import nor_eng_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter bit          EEPROM_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              raise_hit
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] old_byte;
    logic [7:0] new_byte;

    // Fetch the current byte at the program address.
    always_comb old_byte = mem[prog_addr];

    // Choose how a program combines with the stored byte.
    generate
        if (EEPROM_MODE) begin : g_overwrite
            always_comb new_byte = prog_data;
        end else begin : g_and_only
            always_comb new_byte = old_byte & prog_data;
        end
    endgenerate

    // Flag a program data bit that would raise a cleared bit (flash mode only).
    always_comb raise_hit = !EEPROM_MODE && (|((old_byte ^ prog_data) & prog_data));

    // Apply the single write for this cycle.
    always_ff @(posedge clk) begin
        if (fill_we && rst_n) begin
            mem[fill_addr] <= ERASED_BYTE;
        end else if (prog_we) begin
            mem[prog_addr] <= new_byte;
        end
    end

    // Register the read port.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (mem[$past(fill_addr)] == 8'hFF));  // R5

    generate
        if (EEPROM_MODE) begin : g_chk_ee
            AST_PROG_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
                prog_we |=> (mem[$past(prog_addr)] == $past(prog_data)));  // R3
        end else begin : g_chk_fl
            AST_PROG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                prog_we |=> ((mem[$past(prog_addr)] & ~$past(old_byte)) == 8'h00));  // R2
        end
    endgenerate

endmodule

// File: rtl/nor_prog_erase_engine.sv
// NOR program/erase engine top. It screens each request, starts a region fill
// or applies a byte program, and registers the done, err and diagnostic pulses.
// Assumes at most one request per cycle. req_valid is a single-cycle strobe.
module nor_prog_erase_engine
    import nor_eng_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned SUB_LOG2    = 4,
    parameter int unsigned MID_LOG2    = 7,
    parameter int unsigned SECTOR_LOG2 = 8,
    parameter bit          EEPROM_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              wel,
    input  logic              cap_sub,
    input  logic              cap_mid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              zero_to_one
);

    logic              prog_go;
    logic              erase_go;
    logic              reject;
    logic [ADDR_W-1:0] erase_mask;
    logic              fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_fin;
    logic              raise_hit;
    logic              prog_done_q;

    nor_req_screen #(
        .ADDR_W(ADDR_W), .SUB_LOG2(SUB_LOG2),
        .MID_LOG2(MID_LOG2), .SECTOR_LOG2(SECTOR_LOG2)
    ) u_screen (
        .req_valid(req_valid), .req_op(req_op), .wel(wel),
        .cap_sub(cap_sub), .cap_mid(cap_mid), .busy(busy),
        .prog_go(prog_go), .erase_go(erase_go), .reject(reject),
        .erase_mask(erase_mask)
    );

    nor_fill_seq #(.ADDR_W(ADDR_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(erase_go),
        .start_addr(req_addr), .start_mask(erase_mask),
        .busy(busy), .fill_we(fill_we), .fill_addr(fill_addr), .fin(fill_fin)
    );

    nor_byte_store #(.ADDR_W(ADDR_W), .EEPROM_MODE(EEPROM_MODE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_we(fill_we), .fill_addr(fill_addr),
        .prog_we(prog_go), .prog_addr(req_addr), .prog_data(req_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .raise_hit(raise_hit)
    );

    // Register the per-request result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_done_q <= 1'b0;
            err         <= 1'b0;
            zero_to_one <= 1'b0;
        end else begin
            prog_done_q <= prog_go;
            err         <= reject;
            zero_to_one <= prog_go && raise_hit;
        end
    end

    // Merge the completion pulses; a program never finishes in a fill's last cycle.
    always_comb done = prog_done_q | fill_fin;

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> err);  // R10
    AST_NO_WEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wel) |=> err);  // R8
    AST_SUB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1 && !cap_sub) |=> err);  // R7
    AST_FILL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wel) && $past(req_valid)));  // R8
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > 3'd4) |=> (err && !$rose(busy)));  // R12

endmodule

// File: tb/sim_nor_prog_erase_engine.sv
`timescale 1ns/1ps
module sim_nor_prog_erase_engine;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          wel = 1'b0;
    logic          cap_sub = 1'b0;
    logic          cap_mid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, rd_data_e;
    logic          busy, done, err, zero_to_one;
    logic          busy_e, done_e, err_e, z1_e;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    nor_prog_erase_engine #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .wel(wel),
        .cap_sub(cap_sub), .cap_mid(cap_mid), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err),
        .zero_to_one(zero_to_one)
    );

    nor_prog_erase_engine #(.ADDR_W(AW), .EEPROM_MODE(1'b1)) u1_eeprom (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .wel(wel),
        .cap_sub(cap_sub), .cap_mid(cap_mid), .rd_addr(rd_addr),
        .rd_data(rd_data_e), .busy(busy_e), .done(done_e), .err(err_e),
        .zero_to_one(z1_e)
    );

    // Vector layout: {op[3], addr[10], data[8], wel, expected byte[8], exp_err, exp_flag}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 10'h010, 8'hF0, 1'b1, 8'hF0, 1'b0, 1'b0},
        {3'd0, 10'h010, 8'h3C, 1'b1, 8'h30, 1'b0, 1'b1},
        {3'd0, 10'h011, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b0},
        {3'd0, 10'h011, 8'hFF, 1'b1, 8'hA5, 1'b0, 1'b1},
        {3'd0, 10'h3FF, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},
        {3'd0, 10'h200, 8'h7E, 1'b0, 8'hFF, 1'b1, 1'b0},
        {3'd0, 10'h012, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request at the current negedge and sample its pulses one cycle later.
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic w,
                         output logic e_o, output logic dn_o, output logic z_o);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; wel = w;
        @(negedge clk);
        req_valid = 1'b0;
        e_o = err; dn_o = done; z_o = zero_to_one;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd0(input logic [AW-1:0] a, output logic [7:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic rd1(input logic [AW-1:0] a, output logic [7:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data_e;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic e, dn, z;
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", busy, 1);
        chk("R1 err in reset", err, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        wait_idle(n);
        chk("R1 power-up fill cycles", n, DEPTH);
        chk("R1 done after fill", done, 1);
        rd0(10'h155, v); chk("R1 byte erased", v, 8'hFF);

        // R2 R4 R8 R9: program vector table
        for (int i = 0; i < NV; i++) begin
            logic [31:0] t;
            t = VEC[i];
            issue(t[31:29], t[28:19], t[18:11], t[10], e, dn, z);
            chk("R8 err", e, int'(t[1]));
            chk("R9 program done", dn, int'(!t[1]));
            chk("R4 zero_to_one", z, int'(t[0]));
            chk("R9 program no busy", busy, 0);
            rd0(t[28:19], v);
            chk("R2 stored byte", v, int'(t[9:2]));
        end
        // R3: overwrite instance
        rd1(10'h010, v); chk("R3 eeprom overwrite", v, 8'h3C);
        rd1(10'h011, v); chk("R3 eeprom bits back to one", v, 8'hFF);

        // markers outside the small region
        issue(3'd0, 10'h00F, 8'h11, 1'b1, e, dn, z);
        issue(3'd0, 10'h020, 8'h22, 1'b1, e, dn, z);

        // R7: small erase without capability
        cap_sub = 1'b0;
        issue(3'd1, 10'h013, 8'h00, 1'b1, e, dn, z);
        chk("R7 small erase refused err", e, 1);
        chk("R7 small erase no busy", busy, 0);
        rd0(10'h010, v); chk("R7 byte kept", v, 8'h30);

        // R5 R6 R9: small erase, aligned down
        cap_sub = 1'b1;
        issue(3'd1, 10'h013, 8'h00, 1'b1, e, dn, z);
        chk("R5 small erase accepted", e, 0);
        wait_idle(n);
        chk("R9 small busy cycles", n, 16);
        chk("R9 small done", done, 1);
        rd0(10'h010, v); chk("R5 region start", v, 8'hFF);
        rd0(10'h012, v); chk("R5 region mid", v, 8'hFF);
        rd0(10'h00F, v); chk("R5 below region", v, 8'h11);
        rd0(10'h020, v); chk("R11 read after one clock", v, 8'h22);

        // R7 mid without capability, then R6 mid erase
        issue(3'd0, 10'h090, 8'h00, 1'b1, e, dn, z);
        cap_mid = 1'b0;
        issue(3'd2, 10'h0F0, 8'h00, 1'b1, e, dn, z);
        chk("R7 mid erase refused", e, 1);
        rd0(10'h090, v); chk("R7 mid byte kept", v, 8'h00);
        cap_mid = 1'b1;
        issue(3'd2, 10'h0F0, 8'h00, 1'b1, e, dn, z);
        wait_idle(n);
        chk("R6 mid busy cycles", n, 128);
        rd0(10'h090, v); chk("R6 mid region", v, 8'hFF);
        rd0(10'h020, v); chk("R5 below mid region", v, 8'h22);

        // R6 sector erase with R10 request while busy
        issue(3'd0, 10'h2FF, 8'h55, 1'b1, e, dn, z);
        issue(3'd3, 10'h3FF, 8'h00, 1'b1, e, dn, z);
        chk("R6 sector busy", busy, 1);
        issue(3'd0, 10'h00F, 8'h00, 1'b1, e, dn, z);
        chk("R10 refused while busy", e, 1);
        wait_idle(n);
        chk("R9 sector busy remainder", n, 255);
        rd0(10'h3FF, v); chk("R6 sector top", v, 8'hFF);
        rd0(10'h2FF, v); chk("R5 below sector", v, 8'h55);
        rd0(10'h00F, v); chk("R10 byte untouched", v, 8'h11);

        // R12 unknown op
        issue(3'd6, 10'h00F, 8'h00, 1'b1, e, dn, z);
        chk("R12 unknown op err", e, 1);
        chk("R12 unknown op no done", dn, 0);
        rd0(10'h00F, v); chk("R12 byte untouched", v, 8'h11);

        // R8 whole erase without latch
        issue(3'd4, 10'h000, 8'h00, 1'b0, e, dn, z);
        chk("R8 chip erase refused", e, 1);
        chk("R8 chip erase no busy", busy, 0);
        rd0(10'h00F, v); chk("R8 byte untouched", v, 8'h11);

        // R6 whole-array erase
        issue(3'd4, 10'h123, 8'h00, 1'b1, e, dn, z);
        wait_idle(n);
        chk("R6 chip busy cycles", n, DEPTH);
        rd0(10'h00F, v); chk("R6 chip low byte", v, 8'hFF);
        rd0(10'h2FF, v); chk("R6 chip mid byte", v, 8'hFF);
        summary();
    end

endmodule